// File: doc/BRIEF.md
# Streaming Twiddle-Factor Complex Multiplier

This block rotates a serial stream of complex samples by the twiddle factors that sit between two radix-2² butterfly pairs in a pipelined FFT/IFFT. Each sample arrives with a load strobe. A frame counter, local to the block, picks a twiddle from a table of N unit-circle points. The complex product leaves the block a fixed number of cycles later, together with a valid flag. The table size N is a parameter. The first inter-stage position uses N = 64 and the second uses N = 16.

Two flags travel with every sample. The inverse flag conjugates the fetched twiddle, which is what the inverse transform needs. The bit-reverse flag makes the frame counter be read with its bits mirrored, so a stream already in bit-reversed order lands on the correct twiddles. The block needs no reorder buffer ahead of it. The complex product uses three real multipliers instead of four, and it rounds its result back to the sample width.

Top module: `twiddle_mult`

## Requirements
- R1: While reset is held, and on the cycle after it, `out_valid`, `out_re` and `out_im` are all zero, and the frame counter is at 0.
- R2: Table entry k is the pair (round(32768·cos(2πk/N)), round(−32768·sin(2πk/N))) in two's complement Q1.15, clamped to ±32767. Here round(x) means floor(x + 0.5).
- R3: With `in_bitrev` = 0 the counter value is c. With q = c / (N/4) and r = c mod (N/4), the table index is k = s(q)·r, where s maps 1 to 2, maps 2 to 1, and leaves 0 and 3 unchanged.
- R4: With `in_bitrev` = 1, the R3 formula is applied to the counter value with its log2(N) bits mirrored, so that bit 0 becomes the top bit.
- R5: The counter advances by one only on cycles with `in_load` = 1, and returns to 0 after the load at count N−1. Cycles without a load change neither the counter nor the twiddle used for the next sample.
- R6: With `in_inverse` = 1 the imaginary part of the twiddle is negated before the product is formed.
- R7: Each output part equals floor(P/32768 + 0.5), saturated to [−32768, 32767], where P is the exact integer real or imaginary part of the input times the twiddle.
- R8: `out_valid` is `in_load` delayed by exactly 4 clock cycles, and the output data on that cycle belongs to that load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_load | input | 1 | Sample present this cycle |
| in_inverse | input | 1 | 1 = inverse transform (conjugate twiddle) |
| in_bitrev | input | 1 | 1 = stream in bit-reversed order |
| in_re | input | DW | Input sample, real part, signed Q1.15 |
| in_im | input | DW | Input sample, imaginary part, signed Q1.15 |
| out_valid | output | 1 | Product present this cycle |
| out_re | output | DW | Product, real part, signed |
| out_im | output | DW | Product, imaginary part, signed |

## Verification
The two functions that can coincide are the counter wrap and a change of the order or inverse flags. The first load of every new frame takes the wrapped count of 0 under flags that differ from those of the frame just ended. The stimulus places every flag change exactly on a frame boundary, and it puts random idle gaps inside frames, so a wrap also coincides with stalled cycles. Each result is compared within one LSB against a real-number model that keeps its own counter and its own bit mirroring. Any error in the wrap, or in flag sampling at the boundary, therefore shows up as a wrong twiddle on the next sample.

// File: rtl/tfm_pkg.sv
package tfm_pkg;

    // Pipeline depth from load strobe to output valid.
    localparam int PIPE_LAT = 4;

    typedef enum logic {
        XFORM_FWD = 1'b0,
        XFORM_INV = 1'b1
    } xform_e;

    typedef enum logic {
        ORD_NATURAL = 1'b0,
        ORD_MIRROR  = 1'b1
    } order_e;

    // Quarter index permutation: 1 and 2 trade places.
    function automatic logic [1:0] quarter_swap(input logic [1:0] q);
        logic [1:0] s;
        unique case (q)
            2'd1:    s = 2'd2;
            2'd2:    s = 2'd1;
            default: s = q;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tfm_addr_gen.sv
module tfm_addr_gen #(
    parameter int NPTS = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load_i,
    input  tfm_pkg::order_e          order_i,
    output logic [$clog2(NPTS)-1:0]  cnt_o,
    output logic [$clog2(NPTS)-1:0]  addr_o
);
    import tfm_pkg::*;

    localparam int LG   = $clog2(NPTS);
    localparam int QW   = LG - 2;
    localparam logic [LG-1:0] LAST = LG'(NPTS - 1);

    logic [LG-1:0] cnt_q;
    logic [LG-1:0] cnt_mir;
    logic [LG-1:0] c_eff;
    logic [1:0]    quarter;
    logic [QW-1:0] offset;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    for (genvar b = 0; b < LG; b++) begin : g_mirror
        assign cnt_mir[b] = cnt_q[LG-1-b];
    end

    always_comb begin
        c_eff   = (order_i == ORD_MIRROR) ? cnt_mir : cnt_q;
        quarter = c_eff[LG-1 -: 2];
        offset  = c_eff[QW-1:0];
        addr_o  = LG'(quarter_swap(quarter)) * LG'(offset);
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/tfm_rom.sv
module tfm_rom #(
    parameter int NPTS = 64,
    parameter int DW   = 16
) (
    input  logic [$clog2(NPTS)-1:0] addr_i,
    output logic signed [DW-1:0]    re_o,
    output logic signed [DW-1:0]    im_o
);
    localparam int LG   = $clog2(NPTS);
    localparam int FRAC = DW - 1;
    localparam int LIM  = (1 << FRAC) - 1;

    function automatic logic signed [DW-1:0] tw_val(input int k, input bit want_im);
        real ang;
        real v;
        int  r;
        ang = 2.0 * 3.14159265358979323846 * k / NPTS;
        v   = want_im ? -$sin(ang) : $cos(ang);
        r   = $rtoi($floor(v * (2.0 ** FRAC) + 0.5));
        if (r > LIM)  r = LIM;
        if (r < -LIM) r = -LIM;
        return DW'(r);
    endfunction

    logic signed [DW-1:0] re_tab [NPTS];
    logic signed [DW-1:0] im_tab [NPTS];

    for (genvar g = 0; g < NPTS; g++) begin : g_ent
        localparam logic signed [DW-1:0] RE_V = tw_val(g, 1'b0);
        localparam logic signed [DW-1:0] IM_V = tw_val(g, 1'b1);
        assign re_tab[g] = RE_V;
        assign im_tab[g] = IM_V;
    end

    assign re_o = re_tab[addr_i];
    assign im_o = im_tab[addr_i];

endmodule

// File: rtl/tfm_cmul3.sv
module tfm_cmul3 #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 v_i,
    input  logic signed [DW-1:0] ar_i,
    input  logic signed [DW-1:0] ai_i,
    input  logic signed [DW-1:0] br_i,
    input  logic signed [DW-1:0] bi_i,
    output logic                 v_o,
    output logic signed [DW-1:0] pr_o,
    output logic signed [DW-1:0] pi_o
);
    localparam int SW   = DW + 1;
    localparam int PW   = 2 * DW + 1;
    localparam int AW   = 2 * DW + 2;
    localparam int FRAC = DW - 1;
    localparam int RND  = 1 << (FRAC - 1);
    localparam logic signed [AW-1:0] SAT_HI = AW'((1 << (DW - 1)) - 1);
    localparam logic signed [AW-1:0] SAT_LO = -SAT_HI - 1;

    // Stage A: pre-adders
    logic                 va_q;
    logic signed [DW-1:0] ar_q, br_q, bi_q;
    logic signed [SW-1:0] sb_q, sa_q, sd_q;
    // Stage B: three products
    logic                 vb_q;
    logic signed [PW-1:0] m1_q, m2_q, m3_q;
    // Combine
    logic signed [AW-1:0] acc_re, acc_im;

    function automatic logic signed [DW-1:0] round_sat(input logic signed [AW-1:0] x);
        logic signed [AW-1:0] t;
        t = (x + AW'(RND)) >>> FRAC;
        if (t > SAT_HI)      return SAT_HI[DW-1:0];
        else if (t < SAT_LO) return SAT_LO[DW-1:0];
        else                 return t[DW-1:0];
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            va_q <= 1'b0;
            ar_q <= '0;
            br_q <= '0;
            bi_q <= '0;
            sb_q <= '0;
            sa_q <= '0;
            sd_q <= '0;
        end else begin
            va_q <= v_i;
            ar_q <= ar_i;
            br_q <= br_i;
            bi_q <= bi_i;
            sb_q <= SW'(br_i) + SW'(bi_i);
            sa_q <= SW'(ar_i) + SW'(ai_i);
            sd_q <= SW'(ai_i) - SW'(ar_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vb_q <= 1'b0;
            m1_q <= '0;
            m2_q <= '0;
            m3_q <= '0;
        end else begin
            vb_q <= va_q;
            m1_q <= PW'(ar_q) * PW'(sb_q);
            m2_q <= PW'(bi_q) * PW'(sa_q);
            m3_q <= PW'(br_q) * PW'(sd_q);
        end
    end

    always_comb begin
        acc_re = AW'(m1_q) - AW'(m2_q);
        acc_im = AW'(m1_q) + AW'(m3_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_o  <= 1'b0;
            pr_o <= '0;
            pi_o <= '0;
        end else begin
            v_o  <= vb_q;
            pr_o <= round_sat(acc_re);
            pi_o <= round_sat(acc_im);
        end
    end

endmodule

// File: rtl/twiddle_mult.sv
module twiddle_mult #(
    parameter int NPTS = 64,
    parameter int DW   = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_load,
    input  logic                 in_inverse,
    input  logic                 in_bitrev,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_re,
    output logic signed [DW-1:0] out_im
);
    import tfm_pkg::*;

    localparam int LG = $clog2(NPTS);

    xform_e               xform;
    order_e               order;
    logic [LG-1:0]        frame_cnt;
    logic [LG-1:0]        tw_addr;
    logic signed [DW-1:0] tw_re, tw_im;

    logic                 v1_q;
    logic signed [DW-1:0] ar_q, ai_q, br_q, bi_q;

    assign xform = xform_e'(in_inverse);
    assign order = order_e'(in_bitrev);

    tfm_addr_gen #(.NPTS(NPTS)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .load_i  (in_load),
        .order_i (order),
        .cnt_o   (frame_cnt),
        .addr_o  (tw_addr)
    );

    tfm_rom #(.NPTS(NPTS), .DW(DW)) u_rom (
        .addr_i (tw_addr),
        .re_o   (tw_re),
        .im_o   (tw_im)
    );

    // Capture stage: sample and (conjugated) twiddle side by side.
    always_ff @(posedge clk) begin
        if (rst) begin
            v1_q <= 1'b0;
            ar_q <= '0;
            ai_q <= '0;
            br_q <= '0;
            bi_q <= '0;
        end else begin
            v1_q <= in_load;
            ar_q <= in_re;
            ai_q <= in_im;
            br_q <= tw_re;
            bi_q <= (xform == XFORM_INV) ? -tw_im : tw_im;
        end
    end

    tfm_cmul3 #(.DW(DW)) u_mul (
        .clk  (clk),
        .rst  (rst),
        .v_i  (v1_q),
        .ar_i (ar_q),
        .ai_i (ai_q),
        .br_i (br_q),
        .bi_i (bi_q),
        .v_o  (out_valid),
        .pr_o (out_re),
        .pi_o (out_im)
    );

endmodule

// File: rtl/twiddle_mult_checker.sv
module twiddle_mult_checker #(
    parameter int NPTS = 64
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_load,
    input logic                    out_valid,
    input logic [$clog2(NPTS)-1:0] frame_cnt
);
    localparam int LG = $clog2(NPTS);
    localparam logic [LG-1:0] LAST = LG'(NPTS - 1);

    logic [2:0] since_rst;
    logic       was_rst;

    always_ff @(posedge clk) begin
        was_rst <= rst;
        if (rst)                  since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    // R1: pipeline comes out of reset empty
    always @(posedge clk) begin
        if (was_rst === 1'b1) begin
            p_reset_quiet_r1: assert (out_valid == 1'b0);
        end
    end

    // R8: valid is the load strobe four cycles later
    p_valid_delay_r8: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd4) |-> (out_valid == $past(in_load, 4)));

    // R5: idle cycles leave the counter alone
    p_cnt_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !in_load |=> $stable(frame_cnt));

    // R5: a load steps the counter by one
    p_cnt_step_r5: assert property (@(posedge clk) disable iff (rst)
        (in_load && frame_cnt != LAST) |=> (frame_cnt == LG'($past(frame_cnt) + 1'b1)));

    // R5: a load at the last count returns to zero
    p_cnt_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (in_load && frame_cnt == LAST) |=> (frame_cnt == '0));

endmodule

bind twiddle_mult twiddle_mult_checker #(.NPTS(NPTS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_load   (in_load),
    .out_valid (out_valid),
    .frame_cnt (frame_cnt)
);

// File: tb/twiddle_mult_bench.sv
module twiddle_mult_bench;
    localparam int NPTS = 64;
    localparam int DW   = 16;
    localparam int LG   = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                 rst;
    logic                 in_load, in_inverse, in_bitrev;
    logic signed [DW-1:0] in_re, in_im;
    logic                 out_valid;
    logic signed [DW-1:0] out_re, out_im;

    twiddle_mult #(.NPTS(NPTS), .DW(DW)) u_twiddle_mult (
        .clk        (clk),
        .rst        (rst),
        .in_load    (in_load),
        .in_inverse (in_inverse),
        .in_bitrev  (in_bitrev),
        .in_re      (in_re),
        .in_im      (in_im),
        .out_valid  (out_valid),
        .out_re     (out_re),
        .out_im     (out_im)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;
    logic [3:0] hist;
    int    tb_cnt;
    int    q_re[$];
    int    q_im[$];
    string q_tag[$];

    function automatic int clamp(int v, int lo, int hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    // R2: quantized twiddle
    function automatic int tw_q(int k, bit want_im);
        real ang, v;
        ang = 2.0 * 3.14159265358979323846 * k / NPTS;
        v   = want_im ? -$sin(ang) : $cos(ang);
        return clamp(int'($floor(v * 32768.0 + 0.5)), -32767, 32767);
    endfunction

    // R3 / R4: table index from the bench's own counter
    function automatic int bench_k(int cnt, bit mirror);
        int c, q, off, sq;
        c = cnt;
        if (mirror) begin
            c = 0;
            for (int b = 0; b < LG; b++) if (cnt[b]) c |= 1 << (LG - 1 - b);
        end
        q   = c / (NPTS / 4);
        off = c % (NPTS / 4);
        sq  = (q == 1) ? 2 : (q == 2) ? 1 : q;
        return sq * off;
    endfunction

    // R7: rounded, saturated reference
    function automatic int ref_part(real p);
        return clamp(int'($floor(p / 32768.0 + 0.5)), -32768, 32767);
    endfunction

    task automatic check(string tag, bit ok, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic ld, input logic inv, input logic mir,
                         input int re, input int im, input string tag);
        int k, wr, wi, er, ei;
        string t;
        @(negedge clk);
        // R8: valid timing
        check("R8 valid", out_valid == hist[3], int'(out_valid), int'(hist[3]));
        if (hist[3] && q_re.size() > 0) begin
            er = q_re.pop_front();
            ei = q_im.pop_front();
            t  = q_tag.pop_front();
            check({t, " re"}, (int'(out_re) - er <= 1) && (er - int'(out_re) <= 1), int'(out_re), er);
            check({t, " im"}, (int'(out_im) - ei <= 1) && (ei - int'(out_im) <= 1), int'(out_im), ei);
        end
        in_load    = ld;
        in_inverse = inv;
        in_bitrev  = mir;
        in_re      = DW'(re);
        in_im      = DW'(im);
        if (ld) begin
            k  = bench_k(tb_cnt, mir);
            wr = tw_q(k, 1'b0);
            wi = tw_q(k, 1'b1);
            if (inv) wi = -wi;   // R6
            q_re.push_back(ref_part(real'(re) * wr - real'(im) * wi));
            q_im.push_back(ref_part(real'(re) * wi + real'(im) * wr));
            q_tag.push_back(tag);
            tb_cnt = (tb_cnt + 1) % NPTS;   // R5
        end
        hist = {hist[2:0], ld};
    endtask

    function automatic int rnd16();
        return int'($urandom % 65536) - 32768;
    endfunction

    initial begin
        int loads;
        bit inv, mir, ld;
        string tag;
        void'($urandom(32'd20240611));
        rst = 1'b1; in_load = 0; in_inverse = 0; in_bitrev = 0; in_re = '0; in_im = '0;
        hist = '0; tb_cnt = 0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 valid", out_valid == 1'b0, int'(out_valid), 0);
        check("R1 re", out_re == '0, int'(out_re), 0);
        check("R1 im", out_im == '0, int'(out_im), 0);
        rst = 1'b0;

        // R2: unit real input exposes the table directly
        for (int i = 0; i < NPTS; i++) cycle(1, 0, 0, 32767, 0, "R2");

        // Frames with flags switched only on the wrap boundary
        for (int f = 0; f < 8; f++) begin
            mir = (f == 2 || f == 3 || f == 5 || f == 7);
            inv = (f == 4 || f == 5 || f == 7);
            tag = inv ? "R6" : mir ? "R4" : (f == 1) ? "R5" : "R3";
            loads = 0;
            while (loads < NPTS) begin
                ld = (f == 0) ? 1'b1 : (($urandom % 4) != 0);
                cycle(ld, inv, mir, rnd16(), rnd16(), tag);
                if (ld) loads++;
            end
        end

        // R7: full-scale corners force saturation
        for (int i = 0; i < NPTS; i++) begin
            case (i % 3)
                0: cycle(1, i[5], i[4], 32767, 32767, "R7");
                1: cycle(1, i[5], i[4], -32768, -32768, "R7");
                default: cycle(1, i[5], i[4], -32768, 32767, "R7");
            endcase
        end

        repeat (6) cycle(0, 0, 0, 0, 0, "R8");
        check("R8 drained", q_re.size() == 0, q_re.size(), 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule